// File: doc/BRIEF.md
# Small Multi-Operation Integer ALU

This block is a purely combinational arithmetic and logic unit. It takes two unsigned 8-bit operands and a 4-bit operation code, and it drives a 16-bit result. The operations are addition, subtraction in either operand order, increment and decrement of either operand, a full-width 8x8 multiply, bitwise inversion of either operand, bitwise AND, OR and XOR, and a three-way magnitude compare.

One ripple-carry adder serves every add, subtract, step and compare operation. The block feeds that adder with the subtrahend inverted and a carry-in of one when it needs a difference. A shift-and-accumulate array forms the product. A surrounding datapath places the result on the bus by driving the code on `op_sel`. Most results are zero-extended. Subtraction and decrement results are sign-extended two's-complement values.

Top module: `small_alu`

## Requirements
- R1: Code 0 gives the 9-bit sum a+b, carry-out included, in bits 8:0. Bits 15:9 are zero.
- R2: Code 1 gives a-b as a 16-bit two's-complement value. For example, a=0 and b=1 give 0xFFFF.
- R3: Code 2 gives b-a as a 16-bit two's-complement value.
- R4: Code 3 gives a+1 and code 4 gives b+1, both zero-extended. An operand of 0xFF gives 0x0100.
- R5: Code 5 gives a-1 and code 6 gives b-1, both as 16-bit two's-complement values. An operand of zero gives 0xFFFF.
- R6: Code 7 gives the full, untruncated 16-bit product a*b. For example, 0xFF*0xFF gives 0xFE01.
- R7: Code 8 gives ~a and code 9 gives ~b in bits 7:0. The upper byte is zero.
- R8: Code 10 gives a AND b, code 11 gives a OR b, and code 12 gives a XOR b, all in bits 7:0. The upper byte is zero.
- R9: Code 13 sets exactly one of bits 2:0: bit 0 when a equals b, bit 1 when a is less than b, and bit 2 when a is greater than b. All other bits are zero.
- R10: Codes 14 and 15 give a result of zero whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First unsigned operand |
| b_in | input | 8 | Second unsigned operand |
| op_sel | input | 4 | Operation code |
| result | output | 16 | Operation result |

## Verification
The block holds no registers, so every result is due in the same cycle as the operands and code that produce it. There are zero stages between a change on an input and the matching change on `result`. The bench changes inputs just after a rising clock edge and reads `result` at the next falling edge. That leaves half a period for the logic to settle, and no sampling ever lands on the edge where the inputs change. The expected values come from a reference written from the requirements. Directed corner operands and a random sweep over all sixteen codes are compared against it.

// File: rtl/small_alu.sv
module small_alu #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [OPW-1:0] op_sel,
  output logic [2*W-1:0] result
);
  localparam int RW = 2 * W;

  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_SUBA = OPW'(1);
  localparam logic [OPW-1:0] OP_SUBB = OPW'(2);
  localparam logic [OPW-1:0] OP_INCA = OPW'(3);
  localparam logic [OPW-1:0] OP_INCB = OPW'(4);
  localparam logic [OPW-1:0] OP_DECA = OPW'(5);
  localparam logic [OPW-1:0] OP_DECB = OPW'(6);
  localparam logic [OPW-1:0] OP_MUL  = OPW'(7);
  localparam logic [OPW-1:0] OP_NOTA = OPW'(8);
  localparam logic [OPW-1:0] OP_NOTB = OPW'(9);
  localparam logic [OPW-1:0] OP_AND  = OPW'(10);
  localparam logic [OPW-1:0] OP_OR   = OPW'(11);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(12);
  localparam logic [OPW-1:0] OP_CMP  = OPW'(13);

  logic [W-1:0] add_x, add_y, add_s;
  logic         add_ci;
  logic [W:0]   carry;

  always_comb begin
    add_x  = a_in;
    add_y  = b_in;
    add_ci = 1'b0;
    case (op_sel)
      OP_SUBA, OP_CMP: begin add_y = ~b_in; add_ci = 1'b1; end
      OP_SUBB:         begin add_x = b_in; add_y = ~a_in; add_ci = 1'b1; end
      OP_INCA:         begin add_y = '0; add_ci = 1'b1; end
      OP_INCB:         begin add_x = b_in; add_y = '0; add_ci = 1'b1; end
      OP_DECA:         add_y = '1;
      OP_DECB:         begin add_x = b_in; add_y = '1; end
      default: ;
    endcase
  end

  assign carry[0] = add_ci;
  for (genvar i = 0; i < W; i++) begin : g_rca
    assign add_s[i]     = add_x[i] ^ add_y[i] ^ carry[i];
    assign carry[i + 1] = (add_x[i] & add_y[i]) | (carry[i] & (add_x[i] ^ add_y[i]));
  end

  logic [RW-1:0] acc [0:W];
  assign acc[0] = '0;
  for (genvar r = 0; r < W; r++) begin : g_mul
    assign acc[r + 1] = acc[r] + ({{W{1'b0}}, (b_in[r] ? a_in : {W{1'b0}})} << r);
  end

  logic [RW-1:0] zext_sum, sext_diff, cmp_word;
  logic          is_zero;

  assign zext_sum  = {{(RW-W-1){1'b0}}, carry[W], add_s};
  assign sext_diff = {{(RW-W){~carry[W]}}, add_s};
  assign is_zero   = (add_s == '0);
  assign cmp_word  = {{(RW-3){1'b0}}, carry[W] & ~is_zero, ~carry[W], carry[W] & is_zero};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_INCA, OP_INCB:           result = zext_sum;
      OP_SUBA, OP_SUBB, OP_DECA, OP_DECB: result = sext_diff;
      OP_MUL:                             result = acc[W];
      OP_NOTA:                            result = {{W{1'b0}}, ~a_in};
      OP_NOTB:                            result = {{W{1'b0}}, ~b_in};
      OP_AND:                             result = {{W{1'b0}}, a_in & b_in};
      OP_OR:                              result = {{W{1'b0}}, a_in | b_in};
      OP_XOR:                             result = {{W{1'b0}}, a_in ^ b_in};
      OP_CMP:                             result = cmp_word;
      default:                            result = '0;
    endcase
  end
endmodule

module small_alu_props #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic [OPW-1:0] op_sel,
  input logic [2*W-1:0] result
);
  localparam int RW = 2 * W;
  logic [RW-1:0] za, zb;
  assign za = {{W{1'b0}}, a_in};
  assign zb = {{W{1'b0}}, b_in};

  always_comb begin
    if (!$isunknown({a_in, b_in, op_sel, result})) begin
      if (op_sel == OPW'(0))
        assert_add_width_R1: assert (result[RW-1:W+1] == '0 && result >= za && result >= zb);
      if (op_sel == OPW'(1))
        assert_sub_ab_R2: assert (RW'(result + zb) == za);
      if (op_sel == OPW'(2))
        assert_sub_ba_R3: assert (RW'(result + za) == zb);
      if (op_sel == OPW'(3))
        assert_inc_a_R4: assert (RW'(result - 1'b1) == za);
      if (op_sel == OPW'(6))
        assert_dec_b_R5: assert (RW'(result + 1'b1) == zb);
      if (op_sel == OPW'(7) && b_in == W'(1))
        assert_mul_unit_R6: assert (result == za);
      if (op_sel == OPW'(7) && (a_in == '0 || b_in == '0))
        assert_mul_zero_R6: assert (result == '0);
      if (op_sel >= OPW'(8) && op_sel <= OPW'(12))
        assert_logic_upper_R8: assert (result[RW-1:W] == '0);
      if (op_sel == OPW'(13))
        assert_cmp_onehot_R9: assert ($onehot(result[2:0]) && result[RW-1:3] == '0 && result[0] == (a_in == b_in));
      if (op_sel >= OPW'(14))
        assert_unused_zero_R10: assert (result == '0);
    end
  end
endmodule

bind small_alu small_alu_props #(.W(W), .OPW(OPW)) chk (
  .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .result(result)
);

// File: tb/small_alu_test.sv
module small_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic [3:0]  op = 4'd14;
  logic [15:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  small_alu uut (.a_in(a), .b_in(b), .op_sel(op), .result(res));

  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y);
    logic [15:0] zx, zy;
    zx = {8'h00, x};
    zy = {8'h00, y};
    case (o)
      4'd0:  return zx + zy;
      4'd1:  return zx - zy;
      4'd2:  return zy - zx;
      4'd3:  return zx + 16'd1;
      4'd4:  return zy + 16'd1;
      4'd5:  return zx - 16'd1;
      4'd6:  return zy - 16'd1;
      4'd7:  return zx * zy;
      4'd8:  return {8'h00, ~x};
      4'd9:  return {8'h00, ~y};
      4'd10: return {8'h00, x & y};
      4'd11: return {8'h00, x | y};
      4'd12: return {8'h00, x ^ y};
      4'd13: return {13'd0, x > y, x < y, x == y};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic apply(input string req, input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic [15:0] exp);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h got %h expected %h", req, o, x, y, res, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] o, input logic [7:0] x, input logic [7:0] y);
    apply(req, o, x, y, model(o, x, y));
  endtask

  task automatic test_reset_state;
    apply("R10 reset", 4'd14, 8'h00, 8'h00, 16'h0000);
  endtask

  task automatic test_add;
    apply("R1", 4'd0, 8'hFF, 8'hFF, 16'h01FE);
    apply("R1", 4'd0, 8'h12, 8'h34, 16'h0046);
    apply("R1", 4'd0, 8'h80, 8'h80, 16'h0100);
  endtask

  task automatic test_sub;
    apply("R2", 4'd1, 8'h00, 8'h01, 16'hFFFF);
    apply("R2", 4'd1, 8'h50, 8'h20, 16'h0030);
    apply("R2", 4'd1, 8'h00, 8'hFF, 16'hFF01);
    apply("R2", 4'd1, 8'h7A, 8'h7A, 16'h0000);
    apply("R3", 4'd2, 8'h01, 8'h00, 16'hFFFF);
    apply("R3", 4'd2, 8'h10, 8'hFF, 16'h00EF);
  endtask

  task automatic test_step;
    apply("R4", 4'd3, 8'hFF, 8'h00, 16'h0100);
    apply("R4", 4'd3, 8'h41, 8'hFF, 16'h0042);
    apply("R4", 4'd4, 8'h00, 8'hFF, 16'h0100);
    apply("R5", 4'd5, 8'h00, 8'h33, 16'hFFFF);
    apply("R5", 4'd5, 8'h80, 8'h00, 16'h007F);
    apply("R5", 4'd6, 8'h55, 8'h00, 16'hFFFF);
    apply("R5", 4'd6, 8'h55, 8'h01, 16'h0000);
  endtask

  task automatic test_mul;
    apply("R6", 4'd7, 8'hFF, 8'hFF, 16'hFE01);
    apply("R6", 4'd7, 8'h10, 8'h10, 16'h0100);
    apply("R6", 4'd7, 8'h00, 8'hAB, 16'h0000);
    apply("R6", 4'd7, 8'h0D, 8'h0B, 16'h008F);
  endtask

  task automatic test_logic;
    apply("R7", 4'd8, 8'hA5, 8'h00, 16'h005A);
    apply("R7", 4'd9, 8'hFF, 8'h0F, 16'h00F0);
    apply("R8", 4'd10, 8'hF0, 8'h3C, 16'h0030);
    apply("R8", 4'd11, 8'hF0, 8'h0C, 16'h00FC);
    apply("R8", 4'd12, 8'hFF, 8'h0F, 16'h00F0);
  endtask

  task automatic test_compare;
    apply("R9", 4'd13, 8'h44, 8'h44, 16'h0001);
    apply("R9", 4'd13, 8'h00, 8'hFF, 16'h0002);
    apply("R9", 4'd13, 8'hFF, 8'h00, 16'h0004);
    apply("R9", 4'd13, 8'h7F, 8'h80, 16'h0002);
  endtask

  task automatic test_unused;
    apply("R10", 4'd14, 8'hFF, 8'hFF, 16'h0000);
    apply("R10", 4'd15, 8'hA5, 8'h5A, 16'h0000);
  endtask

  task automatic test_random;
    string tags [16] = '{"R1", "R2", "R3", "R4", "R4", "R5", "R5", "R6",
                         "R7", "R7", "R8", "R8", "R8", "R9", "R10", "R10"};
    for (int n = 0; n < 1600; n++) begin
      logic [3:0] o;
      logic [7:0] x, y;
      o = 4'(n % 16);
      x = 8'($urandom);
      y = (n % 7 == 0) ? x : 8'($urandom);
      run(tags[o], o, x, y);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_add();
    test_sub();
    test_step();
    test_mul();
    test_logic();
    test_compare();
    test_unused();
    test_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule